// File: doc/BRIEF.md
# I2C SCL Rate Divider

This block makes the serial clock timing for an I2C controller from the peripheral clock. A prescaler divides the peripheral clock by one plus a small divide field. The result is an internal clock, which must stay below 20 MHz. The block does not produce it as a separate clock: it gives a one-cycle enable pulse, `ick_tick`, once per internal-clock period.

A second counter counts those pulses to form the SCL period. Each period lasts twenty internal cycles, plus eight cycles for every step of a 6-bit stretch field, plus a rounding term. The rounding term covers about 285 ns of rise, fall and internal delay. The period is split into a low phase and a high phase, and the low phase takes the larger half. The byte engine uses a strobe that marks the start of each phase. It also uses a level that says when SCL is to be held low.

Software writes one clock-control word, plus the rounding count, on a separate 5-bit input. The word packs the divide field in its low bits and the stretch field directly above it. A new word is adopted only at the boundary of an SCL period. While the controller enable is low, both counters are held cleared and SCL is released.

Top module: `i2c_scl_clkgen`

## Requirements
- R1: While `ctl_enable` is sampled low at a clock edge, then from the next cycle `scl_hold_low`, `ick_tick`, `low_phase_stb` and `high_phase_stb` are all 0, and they stay 0 for as long as the enable stays low.
- R2: While running, `ick_tick` pulses for one cycle every CDF+1 peripheral-clock cycles, where CDF is the divide field.
- R3: One SCL period lasts (CDF+1)·(20 + 8·SCGD + R) peripheral-clock cycles and holds exactly 20 + 8·SCGD + R ticks. SCGD is the stretch field, from 0 to 63, and R is `rise_cycles`.
- R4: With P = 20 + 8·SCGD + R, the low phase lasts ceil(P/2) ticks and the high phase lasts floor(P/2) ticks.
- R5: `clkctl_word` carries CDF in bits [CDF_W-1:0] and SCGD in bits [CDF_W+5:CDF_W]. CDF_W is a parameter, either 2 or 3, with a default of 3.
- R6: A change of `clkctl_word` or `rise_cycles` while running does not alter the period in progress. It applies from the next period onward.
- R7: In the first cycle after `ctl_enable` is sampled high, the first period begins: `scl_hold_low` is 1 and `low_phase_stb` is 1.
- R8: `low_phase_stb` is 1 in the first cycle of each low phase, and `high_phase_stb` is 1 in the first cycle of each high phase. `scl_hold_low` rises only with `low_phase_stb` and falls only with `high_phase_stb` or on disable. The two strobes are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_enable | input | 1 | Controller enable; 0 holds the dividers cleared |
| clkctl_word | input | CDF_W+6 | Packed divide field (low bits) and stretch field (above) |
| rise_cycles | input | 5 | Rounding term R in internal-clock cycles |
| ick_tick | output | 1 | One-cycle internal-clock enable |
| scl_hold_low | output | 1 | 1 while SCL is to be driven low |
| low_phase_stb | output | 1 | First cycle of a low phase |
| high_phase_stb | output | 1 | First cycle of a high phase |

## Verification
Every output is decoded from registers. Each one therefore responds in the first cycle after the clock edge that samples a stimulus: enable rising (R7) or falling (R1) shows one cycle later. A written word is first visible in the period that follows the next low strobe. The bench drives inputs and samples outputs on the falling edge, so the checks fall exactly one sample after the driving edge. Phase lengths are measured by counting falling-edge samples from one strobe to the next, and the result is compared with formulas evaluated in the bench.

// File: rtl/i2c_sclgen_pkg.sv
package i2c_sclgen_pkg;
  localparam int SCGD_W      = 6;
  localparam int RND_W       = 5;
  localparam int BASE_CYCLES = 20;
  localparam int STEP_CYCLES = 8;
  localparam int MAX_PERIOD  = BASE_CYCLES + STEP_CYCLES * ((1 << SCGD_W) - 1) + ((1 << RND_W) - 1);
  localparam int POS_W       = $clog2(MAX_PERIOD + 1);

  // Ticks in one SCL period.
  function automatic logic [POS_W-1:0] period_len(input logic [SCGD_W-1:0] scgd,
                                                  input logic [RND_W-1:0]  rnd);
    return POS_W'(BASE_CYCLES) + POS_W'(scgd) * POS_W'(STEP_CYCLES) + POS_W'(rnd);
  endfunction

  // Low phase receives the larger half: ceil(p/2).
  function automatic logic [POS_W-1:0] low_len(input logic [POS_W-1:0] p);
    logic [POS_W:0] t;
    t = {1'b0, p} + (POS_W+1)'(1);
    return t[POS_W:1];
  endfunction
endpackage

// File: rtl/sclgen_prescale.sv
module sclgen_prescale #(
  parameter int CDF_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CDF_W-1:0] cdf,
  output logic             tick,
  output logic             at_zero
);
  logic [CDF_W-1:0] cnt;

  assign tick    = run && (cnt == cdf);
  assign at_zero = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + CDF_W'(1);
  end
endmodule

// File: rtl/sclgen_phase.sv
module sclgen_phase
  import i2c_sclgen_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             at_zero,
  input  logic [POS_W-1:0] period,
  input  logic [POS_W-1:0] low_ticks,
  output logic             wrap,
  output logic             scl_low,
  output logic             low_stb,
  output logic             high_stb
);
  logic [POS_W-1:0] pos;

  assign wrap     = tick && (pos == period - POS_W'(1));
  assign scl_low  = run && (pos < low_ticks);
  assign low_stb  = run && at_zero && (pos == '0);
  assign high_stb = run && at_zero && (pos == low_ticks);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pos <= '0;
    else if (!run)  pos <= '0;
    else if (wrap)  pos <= '0;
    else if (tick)  pos <= pos + POS_W'(1);
  end
endmodule

// File: rtl/i2c_scl_clkgen.sv
module i2c_scl_clkgen
  import i2c_sclgen_pkg::*;
#(
  parameter int CDF_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ctl_enable,
  input  logic [CDF_W+SCGD_W-1:0] clkctl_word,
  input  logic [RND_W-1:0]        rise_cycles,
  output logic                    ick_tick,
  output logic                    scl_hold_low,
  output logic                    low_phase_stb,
  output logic                    high_phase_stb
);
  logic              running;
  logic              wrap;
  logic              at_zero;
  logic [CDF_W-1:0]  sh_cdf;
  logic [SCGD_W-1:0] sh_scgd;
  logic [RND_W-1:0]  sh_rnd;
  logic [POS_W-1:0]  period;
  logic [POS_W-1:0]  low_ticks;

  // Shadow copy follows the inputs while idle and is refreshed only at
  // the tick that closes a period.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      sh_cdf  <= '0;
      sh_scgd <= '0;
      sh_rnd  <= '0;
    end else begin
      running <= ctl_enable;
      if (!running || wrap) begin
        sh_cdf  <= clkctl_word[CDF_W-1:0];
        sh_scgd <= clkctl_word[CDF_W +: SCGD_W];
        sh_rnd  <= rise_cycles;
      end
    end
  end

  assign period    = period_len(sh_scgd, sh_rnd);
  assign low_ticks = low_len(period);

  sclgen_prescale #(.CDF_W(CDF_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (running),
    .cdf     (sh_cdf),
    .tick    (ick_tick),
    .at_zero (at_zero)
  );

  sclgen_phase u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (running),
    .tick      (ick_tick),
    .at_zero   (at_zero),
    .period    (period),
    .low_ticks (low_ticks),
    .wrap      (wrap),
    .scl_low   (scl_hold_low),
    .low_stb   (low_phase_stb),
    .high_stb  (high_phase_stb)
  );
endmodule

// File: rtl/sclgen_chk.sv
module sclgen_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic running,
  input logic tick,
  input logic scl_low,
  input logic low_stb,
  input logic high_stb
);
  AST_OFF_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!scl_low && !tick && !low_stb && !high_stb)); // R1

  AST_STB_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(low_stb && high_stb)); // R8

  AST_FALL_WITH_STB: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_low) |-> low_stb); // R8

  AST_RISE_WITH_STB: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(scl_low) && running) |-> high_stb); // R8

  AST_FIRST_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> (low_stb && scl_low)); // R7
endmodule

bind i2c_scl_clkgen sclgen_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (ctl_enable),
  .running  (running),
  .tick     (ick_tick),
  .scl_low  (scl_hold_low),
  .low_stb  (low_phase_stb),
  .high_stb (high_phase_stb)
);

// File: tb/sim_i2c_scl_clkgen.sv
module sim_i2c_scl_clkgen;
  localparam int CLK_PERIOD = 10;
  localparam int GUARD      = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [8:0] cfg = '0;
  logic [4:0] rc = '0;
  logic       tick, scl_lo, lstb, hstb;
  int         total = 0;
  int         bad = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_scl_clkgen u0 (
    .clk            (clk),
    .rst_n          (rst_n),
    .ctl_enable     (en),
    .clkctl_word    (cfg),
    .rise_cycles    (rc),
    .ick_tick       (tick),
    .scl_hold_low   (scl_lo),
    .low_phase_stb  (lstb),
    .high_phase_stb (hstb)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R5: CDF in bits [2:0], SCGD in bits [8:3] for CDF_W = 3
  task automatic set_cfg(input int c, input int s, input int r);
    cfg = {6'(s), 3'(c)};
    rc  = 5'(r);
  endtask

  task automatic go_idle();
    @(negedge clk); en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // Measures one full period, starting at the next low strobe.
  task automatic measure(output int lo, output int hi, output int tk, output int mism);
    int g;
    g = 0; lo = 0; hi = 0; tk = 0; mism = 0;
    while (!lstb && g < GUARD) begin @(negedge clk); g++; end
    while (!hstb && g < GUARD) begin
      if (!scl_lo) mism++;
      lo++; tk += int'(tick); g++;
      @(negedge clk);
    end
    while (!lstb && g < GUARD) begin
      if (scl_lo) mism++;
      hi++; tk += int'(tick); g++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk("R1 reset scl", int'(scl_lo), 0);
    chk("R1 reset tick", int'(tick), 0);
    chk("R1 reset strobes", int'(lstb) + int'(hstb), 0);
  endtask

  task automatic t_period(input int c, input int s, input int r);
    int lo, hi, tk, mm, p;
    go_idle();
    set_cfg(c, s, r);
    en = 1'b1;
    @(negedge clk);
    measure(lo, hi, tk, mm);
    p = 20 + 8 * s + r;
    chk("R4 low phase", lo, (c + 1) * ((p + 1) / 2));
    chk("R4 high phase", hi, (c + 1) * (p / 2));
    chk("R3 period cycles", lo + hi, (c + 1) * p);
    chk("R3 ticks per period", tk, p);
    chk("R8 scl level within phases", mm, 0);
  endtask

  task automatic t_tick_gap(input int c);
    int g, gap;
    go_idle();
    set_cfg(c, 2, 3);
    en = 1'b1;
    @(negedge clk);
    g = 0;
    while (!tick && g < GUARD) begin @(negedge clk); g++; end
    for (int k = 0; k < 3; k++) begin
      gap = 0;
      do begin @(negedge clk); gap++; end while (!tick && gap < GUARD);
      chk("R2 tick spacing", gap, c + 1);
    end
  endtask

  task automatic t_first();
    go_idle();
    set_cfg(0, 0, 0);
    en = 1'b1;
    chk("R1 still released before edge", int'(scl_lo), 0);
    @(negedge clk);
    chk("R7 scl low in first cycle", int'(scl_lo), 1);
    chk("R7 low strobe in first cycle", int'(lstb), 1);
  endtask

  task automatic t_midchange();
    int lo, hi, tk, mm, g;
    go_idle();
    set_cfg(0, 0, 0);
    en = 1'b1;
    @(negedge clk);
    g = 0;
    while (!lstb && g < GUARD) begin @(negedge clk); g++; end
    lo = 0;
    repeat (3) begin lo++; @(negedge clk); end
    set_cfg(0, 1, 0);
    while (!hstb && g < GUARD) begin lo++; g++; @(negedge clk); end
    hi = 0;
    while (!lstb && g < GUARD) begin hi++; g++; @(negedge clk); end
    chk("R6 current low unchanged", lo, 10);
    chk("R6 current high unchanged", hi, 10);
    measure(lo, hi, tk, mm);
    chk("R6 next low uses new word", lo, 14);
    chk("R6 next high uses new word", hi, 14);
  endtask

  task automatic t_disable();
    int act;
    go_idle();
    set_cfg(1, 0, 0);
    en = 1'b1;
    repeat (15) @(negedge clk);
    en = 1'b0;
    act = 0;
    repeat (6) begin
      @(negedge clk);
      act += int'(scl_lo) + int'(tick) + int'(lstb) + int'(hstb);
    end
    chk("R1 outputs quiet after disable", act, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_period(0, 0, 0);
    t_period(2, 3, 5);
    t_period(7, 1, 31);   // R5 max CDF with SCGD above it
    t_period(0, 63, 0);   // R5 max SCGD
    t_tick_gap(4);
    t_tick_gap(0);
    t_first();
    t_midchange();
    t_disable();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule